// File: doc/BRIEF.md
# Gated Sixteen-Bit Timer/Counter

This block is a single 16-bit timer/counter held as two byte registers, a low half and a high half. A 4-bit mode nibble chooses one of four layouts. The first is a 13-bit timer made from a 5-bit prescaler and an 8-bit upper count. The second is a plain 16-bit count. The third is an 8-bit count that reloads from the high byte. The fourth splits the block into two independent 8-bit timers. The same nibble picks what the block counts: machine-cycle ticks, or falling edges seen on an external count pin. It also decides whether an external gate pin must be high for counting to go on.

Software reaches every register through one byte-wide write port. Two sticky overflow flags, one for each half, report wraps to the interrupt logic or to a baud-rate user outside the block. Each flag stays set until its clear strobe is pulsed.

Top module: `tmr_gated`

## Requirements
- R1: While `rst` is high, both count bytes, both flags, the mode nibble and both run bits clear to zero, and the captured count-pin sample clears to 0.
- R2: The write port decodes `wr_sel` as follows: 0 writes the mode nibble from `wr_data[3:0]`, 1 writes the low byte, 2 writes the high byte, and 3 writes the run bits (bit 0 is the main run bit, bit 1 is the split-mode high run bit). A cycle that writes either count byte does no counting.
- R3: Mode nibble bits 1:0 = 0 selects 13-bit mode. Low bits 4:0 form a prescaler that carries into the high byte, and low bits 7:5 keep their value. Wrapping from 1FFFh in the 13 counted bits to zero sets `ovf_lo`.
- R4: Mode bits 1:0 = 1 counts {high, low} as one 16-bit value. The step from FFFFh to 0000h sets `ovf_lo`.
- R5: Mode bits 1:0 = 2 counts only the low byte. A step taken at FFh loads the high byte into the low byte and sets `ovf_lo`, and the high byte does not change.
- R6: Mode bits 1:0 = 3 splits the block. The low byte uses the main controls and `ovf_lo`. The high byte counts every tick while the high run bit is 1, ignoring gate and source, and sets `ovf_hi` when it wraps from FFh. `ovf_hi` is set in no other mode.
- R7: Nibble bit 2 = 0 gives one step per `tick`. Nibble bit 2 = 1 samples `cnt_pin` on each tick and steps only on a tick where the previous sample was 1 and the present value is 0.
- R8: Nibble bit 3 = 1 allows counting only while `gate_pin` is 1. Nibble bit 3 = 0 ignores `gate_pin`.
- R9: With the main run bit at 0, or with `tick` low, the low-half count holds its value.
- R10: A flag stays set until its clear strobe is pulsed. A wrap in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | BYTE_W | Write data |
| cnt_pin | input | 1 | External event input |
| gate_pin | input | 1 | External gate input |
| clr_ovf_lo | input | 1 | Clear strobe for the low flag |
| clr_ovf_hi | input | 1 | Clear strobe for the high flag |
| cnt_lo | output | BYTE_W | Low count byte |
| cnt_hi | output | BYTE_W | High count byte |
| ovf_lo | output | 1 | Low-half overflow flag |
| ovf_hi | output | 1 | High-half overflow flag |

## Verification
The bench builds the block with its defaults: 8-bit bytes and a 5-bit prescaler. With these values, preloading a byte next to its all-ones value brings every wrap and reload within one or two ticks. The bench preloads a 13-bit count with nonzero upper low bits so that both the carry into the high byte and the preservation of low bits 7:5 can be seen. A reference model driven by the same stimulus predicts each cycle. It covers the count-pin edge patterns, the gate levels and a clear strobe that arrives together with a wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    M_13     = 2'd0,
    M_16     = 2'd1,
    M_RELOAD = 2'd2,
    M_SPLIT  = 2'd3
  } tmode_e;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_LO   = 2'd1;
  localparam logic [1:0] SEL_HI   = 2'd2;
  localparam logic [1:0] SEL_RUN  = 2'd3;

  localparam int NIB_W  = 4;
  localparam int B_SRC  = 2;
  localparam int B_GATE = 3;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              cnt_pin,
  input  logic              gate_pin,
  output logic [NIB_W-1:0]  mode_nib,
  output logic              run_lo,
  output logic              run_hi,
  output logic              step_lo,
  output logic              step_hi
);
  logic pin_smp;
  logic fall, src_ok, gate_ok, hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_nib <= '0;
      run_lo   <= 1'b0;
      run_hi   <= 1'b0;
      pin_smp  <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_MODE) mode_nib <= wr_data[NIB_W-1:0];
      if (wr_en && wr_sel == SEL_RUN) begin
        run_lo <= wr_data[0];
        run_hi <= wr_data[1];
      end
      if (tick) pin_smp <= cnt_pin;
    end
  end

  always_comb begin
    fall    = pin_smp & ~cnt_pin;
    src_ok  = mode_nib[B_SRC] ? fall : 1'b1;
    gate_ok = ~mode_nib[B_GATE] | gate_pin;
    hold    = wr_en && (wr_sel == SEL_LO || wr_sel == SEL_HI);
    step_lo = tick & run_lo & gate_ok & src_ok & ~hold;
    step_hi = tick & run_hi & ~hold;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  tmode_e            mode,
  input  logic              step_lo,
  input  logic              step_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        clr,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic [1:0]        flag
);
  localparam int W16 = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_n, hi_n;
  logic [W16-1:0]    sum16;
  logic [1:0]        wrap;

  always_comb begin
    lo_n  = lo;
    hi_n  = hi;
    wrap  = 2'b00;
    sum16 = {hi, lo} + W16'(1);
    case (mode)
      M_13: if (step_lo) begin
        if (&lo[PRESC_W-1:0]) begin
          lo_n[PRESC_W-1:0] = '0;
          hi_n    = hi + BYTE_W'(1);
          wrap[0] = &hi;
        end else begin
          lo_n[PRESC_W-1:0] = lo[PRESC_W-1:0] + PRESC_W'(1);
        end
      end
      M_16: if (step_lo) begin
        {hi_n, lo_n} = sum16;
        wrap[0] = &{hi, lo};
      end
      M_RELOAD: if (step_lo) begin
        if (&lo) begin
          lo_n    = hi;
          wrap[0] = 1'b1;
        end else begin
          lo_n = lo + BYTE_W'(1);
        end
      end
      default: begin
        if (step_lo) begin
          lo_n    = lo + BYTE_W'(1);
          wrap[0] = &lo;
        end
        if (step_hi) begin
          hi_n    = hi + BYTE_W'(1);
          wrap[1] = &hi;
        end
      end
    endcase
    if (wr_lo) lo_n = wr_data;
    if (wr_hi) hi_n = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flag[g] <= 1'b0;
      else     flag[g] <= wrap[g] | (flag[g] & ~clr[g]);
    end
  end
endmodule

// File: rtl/tmr_gated.sv
module tmr_gated
  import tmr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              cnt_pin,
  input  logic              gate_pin,
  input  logic              clr_ovf_lo,
  input  logic              clr_ovf_hi,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              ovf_lo,
  output logic              ovf_hi
);
  logic [NIB_W-1:0] mode_nib;
  logic             run_lo, run_hi, step_lo, step_hi;
  logic [1:0]       flag;

  tmr_ctrl #(.BYTE_W(BYTE_W)) i_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .mode_nib(mode_nib), .run_lo(run_lo), .run_hi(run_hi),
    .step_lo(step_lo), .step_hi(step_hi)
  );

  tmr_count #(.BYTE_W(BYTE_W), .PRESC_W(PRESC_W)) i_count (
    .clk(clk), .rst(rst), .mode(tmode_e'(mode_nib[1:0])),
    .step_lo(step_lo), .step_hi(step_hi),
    .wr_lo(wr_en && wr_sel == SEL_LO), .wr_hi(wr_en && wr_sel == SEL_HI),
    .wr_data(wr_data), .clr({clr_ovf_hi, clr_ovf_lo}),
    .lo(cnt_lo), .hi(cnt_hi), .flag(flag)
  );

  assign ovf_lo = flag[0];
  assign ovf_hi = flag[1];
endmodule

// File: rtl/tmr_gated_chk.sv
module tmr_gated_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic              gate_pin,
  input logic              clr_ovf_lo,
  input logic              clr_ovf_hi,
  input logic [BYTE_W-1:0] cnt_lo,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic              ovf_lo,
  input logic              ovf_hi,
  input logic [3:0]        mode_nib,
  input logic              run_lo
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cnt_lo == '0 && cnt_hi == '0 && !ovf_lo && !ovf_hi));

  a_r9_run_off_holds: assert property (@(posedge clk) disable iff (rst)
    (!run_lo && !wr_en) |=> $stable(cnt_lo));

  a_r9_no_tick_holds: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  a_r8_gate_low_holds: assert property (@(posedge clk) disable iff (rst)
    (mode_nib[3] && !gate_pin && !wr_en) |=> $stable(cnt_lo));

  a_r10_lo_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_lo && !clr_ovf_lo) |=> ovf_lo);

  a_r10_hi_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_hi && !clr_ovf_hi) |=> ovf_hi);

  a_r6_hi_flag_split_only: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_hi) |-> ($past(mode_nib[1:0]) == 2'd3));
endmodule

bind tmr_gated tmr_gated_chk #(.BYTE_W(BYTE_W)) i_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .gate_pin(gate_pin),
  .clr_ovf_lo(clr_ovf_lo), .clr_ovf_hi(clr_ovf_hi),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi),
  .mode_nib(mode_nib), .run_lo(run_lo)
);

// File: tb/test_tmr_gated.sv
module test_tmr_gated;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, wr_en = 1'b0, cnt_pin = 1'b0, gate_pin = 1'b0;
  logic       clr_ovf_lo = 1'b0, clr_ovf_hi = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] cnt_lo, cnt_hi;
  logic       ovf_lo, ovf_hi;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] lo, hi;
    logic       fl, fh;
    string      tag;
  } exp_t;
  exp_t q[$];

  // reference state
  logic [7:0] m_lo = 0, m_hi = 0;
  logic [3:0] m_nib = 0;
  logic m_fl = 0, m_fh = 0, m_run = 0, m_run2 = 0, m_smp = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_gated i_tmr_gated (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .clr_ovf_lo(clr_ovf_lo), .clr_ovf_hi(clr_ovf_hi),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi)
  );

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lo/hi/fl/fh actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic pin, input logic gate,
                      input logic we, input logic [1:0] sel, input logic [7:0] d,
                      input logic cl, input logic ch, input string tag);
    logic sl, sh, hold, wl, wh;
    exp_t e;
    @(negedge clk);
    tick = t; cnt_pin = pin; gate_pin = gate; wr_en = we; wr_sel = sel;
    wr_data = d; clr_ovf_lo = cl; clr_ovf_hi = ch;
    hold = we && (sel == 2'd1 || sel == 2'd2);
    sl = t && m_run && (!m_nib[3] || gate) && (m_nib[2] ? (m_smp && !pin) : 1'b1) && !hold;
    sh = t && m_run2 && !hold;
    wl = 0; wh = 0;
    case (m_nib[1:0])
      2'd0: if (sl) begin
        if (m_lo[4:0] == 5'h1f) begin
          wl = (m_hi == 8'hff); m_lo[4:0] = 0; m_hi = m_hi + 1;
        end else m_lo[4:0] = m_lo[4:0] + 1;
      end
      2'd1: if (sl) begin
        wl = ({m_hi, m_lo} == 16'hffff); {m_hi, m_lo} = {m_hi, m_lo} + 16'd1;
      end
      2'd2: if (sl) begin
        if (m_lo == 8'hff) begin wl = 1; m_lo = m_hi; end
        else m_lo = m_lo + 1;
      end
      default: begin
        if (sl) begin wl = (m_lo == 8'hff); m_lo = m_lo + 1; end
        if (sh) begin wh = (m_hi == 8'hff); m_hi = m_hi + 1; end
      end
    endcase
    if (we && sel == 2'd1) m_lo = d;
    if (we && sel == 2'd2) m_hi = d;
    if (we && sel == 2'd0) m_nib = d[3:0];
    if (we && sel == 2'd3) begin m_run = d[0]; m_run2 = d[1]; end
    if (t) m_smp = pin;
    m_fl = wl | (m_fl & ~cl);
    m_fh = wh | (m_fh & ~ch);
    e.lo = m_lo; e.hi = m_hi; e.fl = m_fl; e.fh = m_fh; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d, input string tag);
    step(1'b0, cnt_pin, gate_pin, 1'b1, sel, d, 1'b0, 1'b0, tag);
  endtask

  task automatic tk(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, gate_pin, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, tag);
  endtask

  // monitor: compares after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, {cnt_lo, cnt_hi, ovf_lo, ovf_hi}, {e.lo, e.hi, e.fl, e.fh});
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {cnt_lo, cnt_hi, ovf_lo, ovf_hi}, 18'd0);
    rst = 1'b0;
    // R2 / R4: 16-bit wrap, write suppresses counting
    wr(2'd0, 8'h01, "R2");
    wr(2'd1, 8'hfe, "R2");
    wr(2'd2, 8'hff, "R2");
    wr(2'd3, 8'h01, "R2");
    tk(1, "R4");
    tk(1, "R4");
    tk(1, "R4");
    step(1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 8'h40, 1'b0, 1'b0, "R2");
    tk(1, "R2");
    // R10: sticky, clear, clear together with wrap
    tk(2, "R10");
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 1'b1, 1'b0, "R10");
    wr(2'd1, 8'hff, "R10");
    wr(2'd2, 8'hff, "R10");
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 1'b1, 1'b0, "R10");
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 1'b1, 1'b0, "R10");
    // R3: 13-bit, upper low bits kept
    wr(2'd0, 8'h00, "R3");
    wr(2'd1, 8'hbe, "R3");
    wr(2'd2, 8'hff, "R3");
    tk(3, "R3");
    // R5: auto reload
    wr(2'd0, 8'h02, "R5");
    wr(2'd2, 8'hfc, "R5");
    wr(2'd1, 8'hfe, "R5");
    tk(4, "R5");
    // R6: split mode
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 1'b1, 1'b0, "R6");
    wr(2'd0, 8'h03, "R6");
    wr(2'd1, 8'h10, "R6");
    wr(2'd2, 8'hfe, "R6");
    wr(2'd3, 8'h02, "R6");
    tk(3, "R6");
    wr(2'd3, 8'h03, "R6");
    tk(2, "R6");
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b1, "R6");
    // R7: counter mode on count-pin falling edges
    wr(2'd3, 8'h01, "R7");
    wr(2'd0, 8'h05, "R7");
    wr(2'd1, 8'h00, "R7");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, "R7");
    // R8: gating
    wr(2'd0, 8'h09, "R8");
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, "R8");
    wr(2'd0, 8'h01, "R8");
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, "R8");
    // R9: run bit off, tick low
    wr(2'd3, 8'h00, "R9");
    tk(3, "R9");
    wr(2'd3, 8'h01, "R9");
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, "R9");
    tk(1, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule